// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Controller

This block arbitrates among eight level-sensitive interrupt requests. It holds a request register, an in-service register and a mask register. From these it decides whether the processor should be interrupted and which level it should service. Priority is a circular order that a single rotation pointer defines: the level the pointer names is the lowest, and the level after it, modulo eight, is the highest. After reset or an init pulse the pointer names level 7, so the controller runs fully nested with level 0 on top.

Software drives the controller through one byte-wide write port. Address 1 loads the mask. Address 0 takes command bytes, which bits 4:3 route. The value 00 selects the end-of-interrupt, rotation and priority command. The value 01 selects the special-mask, poll and read-select command. The values 10 and 11 are ignored. The processor acknowledges through `ack_i`, and the chosen level appears on `ack_level_o`. Instead of an acknowledge, software can arm a poll, so that its next read of address 0 returns the winning level and acts as the acknowledge.

Top module: `lvl8_intc`

## Requirements
- R1: After `rst`, or after an `init_i` pulse, the following defaults hold: in-service, request and mask registers clear; level 0 highest and level 7 lowest; auto-EOI rotation off; special mask mode off; poll disarmed; reads of address 0 return the request register. With no request pending, `int_o` is low.
- R2: Each cycle, the request register samples `irq_i`. `int_o` and the acknowledged level follow the circular order from the rotation pointer. The set-priority command (byte `0xC0|L`) makes level L the lowest, so level (L+1) mod 8 becomes the highest.
- R3: A write at address 1 loads the mask, and a read at address 1 returns it. A request whose mask bit is 1 never raises `int_o` and is never acknowledged.
- R4: A pulse on `ack_i` acknowledges the highest-priority eligible level L. It sets in-service bit L, and `ack_level_o` shows L in the following cycle. When no level is eligible, `ack_level_o` shows 7 and the in-service register is unchanged.
- R5: Outside special mask mode, a level is eligible only if it ranks strictly above every level that is in service. An in-service level therefore blocks itself and every level below it.
- R6: A non-specific EOI (command bits 7:5 = 001, byte `0x20`) clears the in-service bit of the highest-priority level in service. It has no effect when nothing is in service. Bits 2:0 are ignored.
- R7: A specific EOI (byte `0x60|L`) clears in-service bit L, whatever the priority of L.
- R8: Rotate on non-specific EOI (`0xA0`) clears the highest-priority in-service bit and makes that level the lowest. Rotate on specific EOI (`0xE0|L`) clears bit L and makes L the lowest.
- R9: Byte `0x80` turns on auto-EOI rotation, and byte `0x00` turns it off. While it is on, an acknowledge leaves the in-service register unchanged and makes the acknowledged level the lowest.
- R10: With special mask mode on, in-service bits block no other level, and only unmasked requests that are not in service compete. Mode-select byte bit 5 = 1 loads the mode from bit 6 (`0x68` on, `0x28` off). With bit 5 = 0 the mode is unchanged (`0x48`).
- R11: Mode-select byte bit 2 (`0x0C`) arms a poll. The next read at address 0 returns bit 7 set plus the winning level in bits 2:0, or `0x00` if nothing is eligible, and it acknowledges as in R4. Later reads return normal data.
- R12: In a mode-select byte with bit 1 = 1, bit 0 picks what address 0 reads: 0 for the request register (`0x0A`), 1 for the in-service register (`0x0B`). A mode-select byte with bit 7 = 1 is ignored entirely. The command with bits 7:5 = 010 is a no-op. Command bytes with bits 4:3 = 1x are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | One-cycle pulse that restores the reset defaults |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = command byte, 1 = mask |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; consumes an armed poll at address 0 |
| rd_addr_i | input | 1 | 0 = request, in-service or poll byte, 1 = mask |
| rd_data_o | output | 8 | Read data, combinational from the address |
| irq_i | input | 8 | Level-sensitive requests, bit n is level n |
| int_o | output | 1 | An eligible request exists |
| ack_i | input | 1 | Acknowledge pulse |
| ack_level_o | output | 3 | Level taken by the last acknowledge, 7 if none |

## Verification
The hardest state to reach is one where the rotation pointer, several in-service bits and the special mask mode all differ from their defaults at once. Only then does a wrong ordering of the in-service blocking, or a non-specific EOI aimed at the wrong bit, show at the ports. The bench builds that state step by step. It acknowledges chosen request patterns to fill the in-service register, moves the pointer with rotate and set-priority commands, and reads the in-service register back. Exhaustive sweeps of every request pattern under every pointer value, and of every mask against all requests, cover the resolver itself.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NLVL  = 8;
    localparam int LVL_W = $clog2(NLVL);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NLVL-1:0]  vec_t;

    // Command bits 7:5 of a priority/EOI byte
    typedef enum logic [2:0] {
        OP_AEOI_CLR = 3'b000,
        OP_NS_EOI   = 3'b001,
        OP_NOP      = 3'b010,
        OP_SP_EOI   = 3'b011,
        OP_AEOI_SET = 3'b100,
        OP_ROT_NS   = 3'b101,
        OP_SETPRI   = 3'b110,
        OP_ROT_SP   = 3'b111
    } prio_op_e;

    typedef struct packed {
        logic     valid;
        prio_op_e op;
        lvl_t     lvl;
    } prio_cmd_t;

    typedef struct packed {
        logic valid;
        logic smm_we;
        logic smm;
        logic poll;
        logic rsel_we;
        logic rsel;
    } mode_cmd_t;

    // Rank of a level under a rotation pointer: 0 is highest priority.
    function automatic lvl_t rank_of(input lvl_t lvl, input lvl_t lowest);
        return lvl_t'(lvl - lowest - lvl_t'(1));
    endfunction

    // Inverse of rank_of.
    function automatic lvl_t level_of(input lvl_t rank, input lvl_t lowest);
        return lvl_t'(rank + lowest + lvl_t'(1));
    endfunction

endpackage

// File: rtl/intc_prio_resolver.sv
module intc_prio_resolver
    import intc_pkg::*;
#(
    parameter int N = NLVL
) (
    input  logic [N-1:0]         vec_i,
    input  lvl_t                 lowest_i,
    output logic                 valid_o,
    output lvl_t                 lvl_o,
    output lvl_t                 rank_o
);
    logic [N-1:0] by_rank;
    lvl_t         top_rank;

    // Reorder so that index 0 holds the highest-priority level.
    always_comb begin
        for (int r = 0; r < N; r++) begin
            by_rank[r] = vec_i[level_of(lvl_t'(r), lowest_i)];
        end
    end

    // Lowest set rank wins.
    always_comb begin
        top_rank = '0;
        for (int r = N - 1; r >= 0; r--) begin
            if (by_rank[r]) top_rank = lvl_t'(r);
        end
    end

    assign valid_o = |vec_i;
    assign rank_o  = top_rank;
    assign lvl_o   = level_of(top_rank, lowest_i);

endmodule

// File: rtl/intc_cmd_decode.sv
module intc_cmd_decode
    import intc_pkg::*;
(
    input  logic      wr_en_i,
    input  logic      wr_addr_i,
    input  logic [7:0] wr_data_i,
    output prio_cmd_t prio_o,
    output mode_cmd_t mode_o,
    output logic      mask_we_o,
    output vec_t      mask_d_o
);
    logic cmd_wr;
    assign cmd_wr = wr_en_i && !wr_addr_i;

    always_comb begin
        prio_o.valid = cmd_wr && (wr_data_i[4:3] == 2'b00);
        prio_o.op    = prio_op_e'(wr_data_i[7:5]);
        prio_o.lvl   = wr_data_i[LVL_W-1:0];
    end

    always_comb begin
        // reserved bit 7 must be 0, otherwise the byte is dropped
        mode_o.valid   = cmd_wr && (wr_data_i[4:3] == 2'b01) && !wr_data_i[7];
        mode_o.smm_we  = wr_data_i[5];
        mode_o.smm     = wr_data_i[6];
        mode_o.poll    = wr_data_i[2];
        mode_o.rsel_we = wr_data_i[1];
        mode_o.rsel    = wr_data_i[0];
    end

    assign mask_we_o = wr_en_i && wr_addr_i;
    assign mask_d_o  = wr_data_i;

endmodule

// File: rtl/lvl8_intc.sv
module lvl8_intc
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init_i,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    input  logic [7:0] irq_i,
    output logic       int_o,
    input  logic       ack_i,
    output logic [2:0] ack_level_o
);
    // Architectural state
    vec_t irr_q, isr_q, imr_q;
    lvl_t low_q, ack_lvl_q;
    logic aeoi_q, smm_q, poll_q, rsel_q;

    // Decoded commands
    prio_cmd_t prio_cmd;
    mode_cmd_t mode_cmd;
    logic      mask_we;
    vec_t      mask_d;

    intc_cmd_decode u_dec (
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .prio_o   (prio_cmd),
        .mode_o   (mode_cmd),
        .mask_we_o(mask_we),
        .mask_d_o (mask_d)
    );

    // Candidate requests
    vec_t pend, cand;
    assign pend = irr_q & ~imr_q;
    assign cand = smm_q ? (pend & ~isr_q) : pend;

    logic req_vld, is_vld;
    lvl_t req_lvl, req_rank, is_lvl, is_rank;

    intc_prio_resolver #(.N(NLVL)) u_req (
        .vec_i   (cand),
        .lowest_i(low_q),
        .valid_o (req_vld),
        .lvl_o   (req_lvl),
        .rank_o  (req_rank)
    );

    intc_prio_resolver #(.N(NLVL)) u_isr (
        .vec_i   (isr_q),
        .lowest_i(low_q),
        .valid_o (is_vld),
        .lvl_o   (is_lvl),
        .rank_o  (is_rank)
    );

    logic grant_vld;
    assign grant_vld = req_vld && (smm_q || !is_vld || (req_rank < is_rank));
    assign int_o     = grant_vld;

    // An acknowledge arrives either on the pin or as a polled read
    logic poll_rd, take;
    assign poll_rd = rd_en_i && !rd_addr_i && poll_q;
    assign take    = ack_i || poll_rd;

    logic [7:0] poll_byte;
    always_comb begin
        poll_byte = '0;
        if (grant_vld) begin
            poll_byte[7]         = 1'b1;
            poll_byte[LVL_W-1:0] = req_lvl;
        end
    end

    always_comb begin
        if (rd_addr_i)   rd_data_o = imr_q;
        else if (poll_q) rd_data_o = poll_byte;
        else if (rsel_q) rd_data_o = isr_q;
        else             rd_data_o = irr_q;
    end

    assign ack_level_o = ack_lvl_q;

    // Next state of in-service register, pointer and auto-EOI mode
    vec_t isr_n;
    lvl_t low_n;
    logic aeoi_n;

    always_comb begin
        isr_n  = isr_q;
        low_n  = low_q;
        aeoi_n = aeoi_q;
        if (prio_cmd.valid) begin
            case (prio_cmd.op)
                OP_AEOI_CLR: aeoi_n = 1'b0;
                OP_AEOI_SET: aeoi_n = 1'b1;
                OP_NS_EOI: begin
                    if (is_vld) isr_n[is_lvl] = 1'b0;
                end
                OP_ROT_NS: begin
                    if (is_vld) begin
                        isr_n[is_lvl] = 1'b0;
                        low_n         = is_lvl;
                    end
                end
                OP_SP_EOI: isr_n[prio_cmd.lvl] = 1'b0;
                OP_ROT_SP: begin
                    isr_n[prio_cmd.lvl] = 1'b0;
                    low_n               = prio_cmd.lvl;
                end
                OP_SETPRI: low_n = prio_cmd.lvl;
                default: ;
            endcase
        end
        if (take && grant_vld) begin
            if (aeoi_q) low_n = req_lvl;
            else        isr_n[req_lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            irr_q     <= '0;
            isr_q     <= '0;
            imr_q     <= '0;
            low_q     <= lvl_t'(NLVL - 1);
            ack_lvl_q <= '0;
            aeoi_q    <= 1'b0;
            smm_q     <= 1'b0;
            poll_q    <= 1'b0;
            rsel_q    <= 1'b0;
        end else begin
            irr_q  <= irq_i;
            isr_q  <= isr_n;
            low_q  <= low_n;
            aeoi_q <= aeoi_n;
            if (mask_we) imr_q <= mask_d;
            if (ack_i) ack_lvl_q <= grant_vld ? req_lvl : lvl_t'(NLVL - 1);
            if (mode_cmd.valid && mode_cmd.smm_we)  smm_q  <= mode_cmd.smm;
            if (mode_cmd.valid && mode_cmd.rsel_we) rsel_q <= mode_cmd.rsel;
            if (mode_cmd.valid && mode_cmd.poll)    poll_q <= 1'b1;
            else if (poll_rd)                       poll_q <= 1'b0;
        end
    end

endmodule

// File: rtl/intc_checker.sv
module intc_checker (
    input logic       clk,
    input logic       rst,
    input logic       init_i,
    input logic       wr_en_i,
    input logic       wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic       rd_en_i,
    input logic       ack_i,
    input logic       int_o,
    input logic [2:0] ack_level_o,
    input logic [7:0] irr_q,
    input logic [7:0] isr_q,
    input logic [7:0] imr_q,
    input logic [2:0] low_q,
    input logic       aeoi_q,
    input logic       smm_q,
    input logic       poll_q
);
    logic cmd_wr;
    assign cmd_wr = wr_en_i && !wr_addr_i;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (isr_q == 8'h00 && imr_q == 8'h00 && low_q == 3'd7 && !int_o)); // R1

    AST_SETPRI_POINTER: assert property (@(posedge clk) disable iff (rst || init_i)
        (cmd_wr && wr_data_i[7:3] == 5'b11000 && !ack_i) |=> low_q == $past(wr_data_i[2:0])); // R2

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst || init_i)
        (wr_en_i && wr_addr_i) |=> imr_q == $past(wr_data_i)); // R3

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst || init_i)
        int_o |-> ((irr_q & ~imr_q) != 8'h00)); // R3

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst || init_i)
        (ack_i && int_o && !aeoi_q && !wr_en_i) |=> isr_q[ack_level_o]); // R4

    AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst || init_i)
        (cmd_wr && wr_data_i[7:3] == 5'b01100 && !ack_i && !rd_en_i)
        |=> !isr_q[$past(wr_data_i[2:0])]); // R7

    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst || init_i)
        (ack_i && aeoi_q && !wr_en_i && !rd_en_i) |=> isr_q == $past(isr_q)); // R9

    AST_RSVD_MODE_BYTE: assert property (@(posedge clk) disable iff (rst || init_i)
        (cmd_wr && wr_data_i[4:3] == 2'b01 && wr_data_i[7] && !rd_en_i)
        |=> (smm_q == $past(smm_q) && poll_q == $past(poll_q))); // R12

endmodule

bind lvl8_intc intc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .ack_i      (ack_i),
    .int_o      (int_o),
    .ack_level_o(ack_level_o),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .imr_q      (imr_q),
    .low_q      (low_q),
    .aeoi_q     (aeoi_q),
    .smm_q      (smm_q),
    .poll_q     (poll_q)
);

// File: tb/tb_lvl8_intc.sv
module tb_lvl8_intc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_en_i = 1'b0;
    logic       rd_addr_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [7:0] irq_i = '0;
    logic       int_o;
    logic       ack_i = 1'b0;
    logic [2:0] ack_level_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    lvl8_intc dut (
        .clk(clk), .rst(rst), .init_i(init_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .irq_i(irq_i), .int_o(int_o), .ack_i(ack_i), .ack_level_o(ack_level_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        rd_en_i = 1'b1; rd_addr_i = a;
        #1 d = rd_data_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic rd_isr(output logic [7:0] d);
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq_i = v;
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    // Highest-priority set level given the lowest-priority level
    function automatic int winner(input logic [7:0] v, input int lowest);
        for (int i = 1; i <= 8; i++) begin
            if (v[(lowest + i) % 8]) return (lowest + i) % 8;
        end
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int w;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset defaults
        check("R1 int after reset", int_o, 0);
        rd(1'b1, d); check("R1 mask after reset", d, 8'h00);
        rd(1'b0, d); check("R1 request read after reset", d, 8'h00);
        set_irq(8'h24);
        rd(1'b0, d); check("R1 default read selects requests", d, 8'h24);
        check("R1 int with request", int_o, 1);

        // R2 sweep every pointer and every request pattern
        for (int low = 0; low < 8; low++) begin
            wr(1'b0, 8'hC0 | 8'(low));
            for (int p = 0; p < 256; p++) begin
                set_irq(8'(p));
                check("R2 int", int_o, (p != 0) ? 1 : 0);
                if (p != 0) begin
                    w = winner(8'(p), low);
                    do_ack();
                    check("R2 ack level", ack_level_o, w);
                    wr(1'b0, 8'h60 | 8'(w));
                end
            end
        end
        set_irq(8'h00);
        wr(1'b0, 8'hC7);

        // R3 sweep every mask against all requests
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            rd(1'b1, d); check("R3 mask readback", d, m);
            set_irq(8'hFF);
            check("R3 int under mask", int_o, (m != 255) ? 1 : 0);
            if (m != 255) begin
                w = winner(~8'(m), 7);
                do_ack();
                check("R3 ack skips masked", ack_level_o, w);
                wr(1'b0, 8'h60 | 8'(w));
            end
            set_irq(8'h00);
        end
        wr(1'b1, 8'h00);

        // R4 acknowledge
        do_ack();
        check("R4 empty ack level", ack_level_o, 7);
        rd_isr(d); check("R4 empty ack isr", d, 8'h00);
        set_irq(8'h08);
        do_ack();
        check("R4 ack level", ack_level_o, 3);
        rd_isr(d); check("R4 isr set", d, 8'h08);

        // R5 in-service blocking
        set_irq(8'h28);
        check("R5 lower blocked", int_o, 0);
        set_irq(8'h0A);
        check("R5 higher passes", int_o, 1);
        do_ack();
        check("R5 nested ack", ack_level_o, 1);
        rd_isr(d); check("R5 isr nested", d, 8'h0A);

        // R6 non-specific EOI, level bits ignored
        wr(1'b0, 8'h27);
        rd_isr(d); check("R6 ns eoi clears top", d, 8'h08);
        wr(1'b0, 8'h20);
        rd_isr(d); check("R6 ns eoi second", d, 8'h00);
        wr(1'b0, 8'h20);
        rd_isr(d); check("R6 ns eoi empty", d, 8'h00);

        // R7 specific EOI
        set_irq(8'h40); do_ack(); check("R7 ack 6", ack_level_o, 6);
        set_irq(8'h44); do_ack(); check("R7 ack 2", ack_level_o, 2);
        wr(1'b0, 8'h66);
        rd_isr(d); check("R7 clears lower level", d, 8'h04);
        wr(1'b0, 8'h62);
        rd_isr(d); check("R7 clears named level", d, 8'h00);

        // R8 rotate on EOI
        set_irq(8'h10); do_ack(); check("R8 ack 4", ack_level_o, 4);
        wr(1'b0, 8'hA0);
        rd_isr(d); check("R8 rot ns clears", d, 8'h00);
        set_irq(8'hFF); do_ack();
        check("R8 after rot ns", ack_level_o, 5);
        wr(1'b0, 8'hE5);
        rd_isr(d); check("R8 rot sp clears", d, 8'h00);
        set_irq(8'h41); do_ack();
        check("R8 after rot sp", ack_level_o, 6);
        wr(1'b0, 8'h66);
        wr(1'b0, 8'hC7);

        // R9 auto-EOI rotation
        wr(1'b0, 8'h80);
        set_irq(8'h06);
        do_ack(); check("R9 first", ack_level_o, 1);
        rd_isr(d); check("R9 isr untouched", d, 8'h00);
        do_ack(); check("R9 rotated", ack_level_o, 2);
        do_ack(); check("R9 rotated again", ack_level_o, 1);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'hC7);
        do_ack(); check("R9 off ack", ack_level_o, 1);
        rd_isr(d); check("R9 off isr", d, 8'h02);
        check("R9 off blocks", int_o, 0);
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R10 special mask mode
        set_irq(8'h01); do_ack(); check("R10 ack 0", ack_level_o, 0);
        set_irq(8'h81);
        check("R10 blocked normally", int_o, 0);
        wr(1'b0, 8'h48);
        check("R10 enable bit clear ignored", int_o, 0);
        wr(1'b0, 8'h68);
        check("R10 smm unblocks", int_o, 1);
        do_ack(); check("R10 smm ack", ack_level_o, 7);
        wr(1'b0, 8'h28);
        rd_isr(d); check("R10 isr both", d, 8'h81);
        check("R10 smm off", int_o, 0);
        wr(1'b0, 8'h20); wr(1'b0, 8'h20);
        rd_isr(d); check("R10 isr cleared", d, 8'h00);

        // R11 poll
        set_irq(8'h30);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); check("R11 poll byte", d, 8'h84);
        rd(1'b0, d); check("R11 poll consumed and isr set", d, 8'h10);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); check("R11 empty poll", d, 8'h00);
        rd_isr(d); check("R11 empty poll isr", d, 8'h00);

        // R12 read select, reserved bit, no-op, ignored selects
        wr(1'b0, 8'h0A);
        set_irq(8'h5A);
        rd(1'b0, d); check("R12 request select", d, 8'h5A);
        wr(1'b0, 8'h8B);
        rd(1'b0, d); check("R12 reserved select ignored", d, 8'h5A);
        wr(1'b0, 8'h8C);
        rd(1'b0, d); check("R12 reserved poll ignored", d, 8'h5A);
        set_irq(8'h08); do_ack(); check("R12 ack 3", ack_level_o, 3);
        wr(1'b0, 8'h43);
        rd_isr(d); check("R12 nop", d, 8'h08);
        wr(1'b0, 8'h73);
        wr(1'b0, 8'h7B);
        rd_isr(d); check("R12 select 1x ignored", d, 8'h08);
        wr(1'b0, 8'h63);
        set_irq(8'h00);

        // R1 init pulse
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'hC3);
        init_i = 1'b1; @(negedge clk); init_i = 1'b0;
        rd(1'b1, d); check("R1 init mask", d, 8'h00);
        set_irq(8'hFF);
        rd(1'b0, d); check("R1 init read select", d, 8'hFF);
        do_ack(); check("R1 init priority", ack_level_o, 0);
        check("R1 init smm off", int_o, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule